// File: doc/BRIEF.md
# Masked Interrupt Collector

This block gathers five single-cycle event pulses from neighbouring peripheral logic (two countdown timer underflows, a clock alarm match, a shift-register completion and an external edge flag) into a byte-wide event register. A companion enable register decides which of those latched events may raise the summary request bit and drive the active-low interrupt line toward the processor.

Software updates the enable register with a set/clear protocol. The top bit of the written byte selects whether the other ones in the byte set or clear the matching enable bits. Enable bits written as zero are left alone. Reading the event register returns its current contents and then empties it, which withdraws the interrupt. An event that coincides with that clearing read is kept for the next read.

Top module: `irq_collect_top`

## Requirements
- R1: After reset, the read word is 0x00, every enable bit is clear and `irq_n` is high.
- R2: A one-cycle pulse on a source input sets its event bit at the next clock edge. The bit positions are 0 for timer A, 1 for timer B, 2 for the alarm, 3 for the serial port and 4 for the flag pin. The bit stays set whatever the enable bits hold.
- R3: A write with bit 7 = 1 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A write with bit 7 = 0 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged. Data bits 5 and 6 are ignored.
- R5: Bit 7 of the read word (the summary) is 1 exactly when some event bit and its enable bit are both 1. `irq_n` is the inverse of that summary, with no extra register delay. Bits 5 and 6 always read 0.
- R6: A read strobe returns the register value in the same cycle. From the next edge on, all event bits and the summary are 0 and `irq_n` is high.
- R7: A source pulse in the same cycle as a read strobe leaves its event bit set after the read clears the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Source event pulses, one per source |
| rd_i | input | 1 | Read strobe for the event register (clears it) |
| rd_data_o | output | 8 | Event register read word |
| wr_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | 8 | Enable write word; bit 7 selects set or clear |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
In one clock cycle a clearing read can coincide with a new source pulse, and an enable write can coincide with either of them. The bench drives random reads, writes and pulses, and places the read and the pulse in the same cycle many times on purpose. A reference model in the bench applies the rule that the event wins the collision. It compares the read word and `irq_n` on every clock.

// File: rtl/irq_collect_pkg.sv
package irq_collect_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned WORDW = 8;
  localparam int unsigned SELB  = WORDW - 1;
  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [WORDW-1:0] word_t;
  typedef enum logic {EN_CLEAR = 1'b0, EN_SET = 1'b1} en_op_e;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch
  import irq_collect_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt_i,
  input  logic     clr_i,
  output src_vec_t flags_o
);
  src_vec_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_i) flags_d = '0;
    flags_d = flags_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_collect_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  word_t    wr_data_i,
  output src_vec_t mask_o
);
  src_vec_t mask_q, mask_d, sel;
  en_op_e   op;

  assign sel = wr_data_i[NSRC-1:0];
  assign op  = en_op_e'(wr_data_i[SELB]);

  always_comb begin
    mask_d = mask_q;
    if (wr_i) begin
      for (int i = 0; i < NSRC; i++) begin
        if (sel[i]) mask_d[i] = (op == EN_SET);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_collect_top.sv
module irq_collect_top
  import irq_collect_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] evt_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic       irq_n
);
  src_vec_t flags, mask;
  logic     summary;

  irq_evt_latch u_latch (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(rd_i), .flags_o(flags)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_data_i(wr_data_i), .mask_o(mask)
  );

  assign summary = |(flags & mask);

  always_comb begin
    rd_data_o = '0;
    rd_data_o[NSRC-1:0] = flags;
    rd_data_o[SELB]     = summary;
  end

  assign irq_n = ~summary;
endmodule

module irq_collect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] evt_i,
  input logic       rd_i,
  input logic [7:0] rd_data_o,
  input logic       irq_n
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (rd_data_o == 8'h00 && irq_n)); // R1
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> ((rd_data_o[4:0] & $past(evt_i)) == $past(evt_i))); // R2
  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((rd_data_o[4:0] & $past(rd_data_o[4:0])) == $past(rd_data_o[4:0]))); // R2
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) irq_n == !rd_data_o[7]); // R5
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n) rd_data_o[6:5] == 2'b00); // R5
  AST_SUMMARY_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[7] |-> (rd_data_o[4:0] != 5'd0)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt_i == 5'd0) |=> (rd_data_o == 8'h00 && irq_n)); // R6
  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (rd_data_o[4:0] == $past(evt_i))); // R7
endmodule

bind irq_collect_top irq_collect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_i(rd_i),
  .rd_data_o(rd_data_o), .irq_n(irq_n)
);

// File: tb/irq_collect_top_bench.sv
module irq_collect_top_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] evt_i = '0;
  logic       rd_i = 0;
  logic [7:0] rd_data_o;
  logic       wr_i = 0;
  logic [7:0] wr_data_i = '0;
  logic       irq_n;

  int n_cmp = 0, n_bad = 0;
  logic [4:0] m_flag = '0, m_mask = '0;

  always #10 clk = ~clk;

  irq_collect_top u_irq_collect_top (.*);

  function automatic logic [7:0] exp_word();
    logic [7:0] w = 8'h00;
    w[4:0] = m_flag;
    w[7] = (m_flag & m_mask) != 0;
    return w;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(req, rd_data_o, exp_word());
    check({req, "_irq"}, {7'd0, irq_n}, {7'd0, ~exp_word()[7]});
  endtask

  // Drive at negedge, step the model, compare mid-high phase after the edge.
  task automatic step(logic [4:0] e, logic r, logic w, logic [7:0] wd, string req);
    @(negedge clk);
    evt_i = e; rd_i = r; wr_i = w; wr_data_i = wd;
    if (r) check({req, "_rdval"}, rd_data_o, exp_word());
    @(posedge clk);
    if (r) m_flag = 0;
    m_flag |= e;
    if (w) for (int i = 0; i < 5; i++)
      if (wd[i]) m_mask[i] = wd[7];
    #5;
    compare(req);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #35;
    compare("R1");
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, "R1");
    step(5'b00101, 0, 0, 0, "R2");           // flags set with mask clear
    step(0, 0, 1, 8'h81, "R3");              // enable timer A -> summary
    step(0, 0, 1, 8'h9E, "R3");              // set the rest
    step(0, 0, 1, 8'h64, "R4");              // clear alarm; bits 5,6 ignored
    step(0, 0, 1, 8'h01, "R4");              // clear timer A -> no request
    step(0, 0, 1, 8'h01 | 8'h80, "R5");
    step(0, 1, 0, 0, "R6");                  // read clears
    step(5'b10000, 1, 0, 0, "R7");           // collide: flag survives
    step(0, 1, 1, 8'h10, "R7");              // read while mask write
    for (int k = 0; k < 2000; k++) begin
      logic [4:0] e;
      e = ($urandom % 4 == 0) ? 5'(1 << ($urandom % 5)) : 5'd0;
      step(e, ($urandom % 5) == 0, ($urandom % 6) == 0, 8'($urandom), "R2");
    end
    for (int k = 0; k < 200; k++)
      step(5'(1 << (k % 5)), 1, 0, 0, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule